// File: doc/BRIEF.md
# Cascadable Parallel-In Serial-Out Shift Register

This block holds one or more 8-bit sections in a chain. A level-sensitive load input copies a parallel word into every stage while it is held low. The register then moves that word out one bit at a time, most significant bit first, on each rising edge of a combined shift clock. The shift clock is the logical OR of two inputs that can be swapped freely, so either input can serve as an active-low enable that freezes the register while it is high.

All control pins come from outside the system clock domain. The load input, both shift-clock inputs and the serial input pass through two-flop synchronisers running on the fast system clock. A shift is recognised as a 0-to-1 transition of the synchronised OR of the two clock inputs. The serial input feeds stage 0 of the first section. Each section's last stage feeds the next section's stage 0. The last stage of the final section drives a true output and an inverted output, so a group of N sections converts an 8×N-bit word into a single serial stream.

Top module: `piso_chain`

## Requirements
- R1: After synchronous reset, `ser_o` is 0 and `ser_n_o` is 1, and all stages hold 0.
- R2: While `load_n_i` is low, the whole chain follows `par_i` continuously, whatever the clock inputs do. Bit `par_i[k]` maps to section k/8, stage k%8, and `ser_o` shows `par_i[8N-1]`.
- R3: While `load_n_i` is high, each rising edge of (`sclk_a_i` OR `sclk_b_i`) moves every stage one place toward the output, and `ser_i` enters stage 0 of the first section. The effect reaches `ser_o` on the third system-clock edge after the input change.
- R4: While `sclk_b_i` is high, toggling `sclk_a_i` causes no shift. A fall of `sclk_b_i` causes no shift either.
- R5: The two clock inputs are interchangeable. Pulsing `sclk_b_i` with `sclk_a_i` low shifts exactly as pulsing `sclk_a_i` with `sclk_b_i` low does.
- R6: A low-to-high change of the enable-side input while the other clock input is low produces a shift.
- R7: Releasing the load (low to high) causes no shift, whether a clock input is high at that moment or both are low.
- R8: `ser_n_o` is always the complement of `ser_o`.
- R9: After a load, a chain of N sections emits `par_i[8N-1]` down to `par_i[0]` over 8×N shifts. The serial-input bits follow in the order they entered.
- R10: A clock input held high for many system cycles produces exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n_i | input | 1 | Active-low level-sensitive parallel load |
| sclk_a_i | input | 1 | Shift clock input A (OR-combined with B) |
| sclk_b_i | input | 1 | Shift clock input B, usable as active-low enable |
| ser_i | input | 1 | Serial data into stage 0 of the first section |
| par_i | input | 8*N | Parallel word, bit k to section k/8 stage k%8 |
| ser_o | output | 1 | Last stage of the final section |
| ser_n_o | output | 1 | Complement of `ser_o` |

## Verification
The assertions check the per-cycle stage behaviour on every cycle. An active load captures the parallel word on the next cycle. A shift pulse moves the stages one place with the serial input entering stage 0. With neither load nor shift, every stage holds its value. Shift pulses are never issued on back-to-back cycles. Only the bench scenarios can show the end-to-end behaviour: that the enable gating holds the data, that the clock inputs can be swapped, that a rising enable while the clock is low shifts, that load release causes no shift, and that the cascade order matches a reference queue.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int SECT_W = 8;

    typedef logic [SECT_W-1:0] stage_t;

    // Control pins bundled for synchronisation
    typedef struct packed {
        logic load_n;
        logic clk_a;
        logic clk_b;
        logic ser;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle values: load inactive, clocks low, serial low
    localparam ctl_t CTL_IDLE = '{load_n: 1'b1, clk_a: 1'b0, clk_b: 1'b0, ser: 1'b0};

    function automatic stage_t shift_in(stage_t s, logic d);
        return {s[SECT_W-2:0], d};
    endfunction

endpackage

// File: rtl/piso_sync.sv
module piso_sync
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t d_i,
    output ctl_t q_o
);
    ctl_t meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= CTL_IDLE;
            q_o    <= CTL_IDLE;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/piso_edge.sv
module piso_edge
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    output logic load_o,
    output logic shift_o
);
    logic comb_clk;
    logic prev_q;

    assign comb_clk = ctl_i.clk_a | ctl_i.clk_b;
    assign load_o   = ~ctl_i.load_n;
    // Shift only on a rising edge of the combined clock, and only when not loading
    assign shift_o  = comb_clk & ~prev_q & ctl_i.load_n;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= comb_clk;
    end

    // R10: one edge gives one pulse
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        shift_o |=> !shift_o);
endmodule

// File: rtl/piso_section.sv
module piso_section
    import piso_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  logic   shift_i,
    input  stage_t par_i,
    input  logic   din_i,
    output stage_t stage_o
);
    always_ff @(posedge clk) begin
        if (rst)          stage_o <= '0;
        else if (load_i)  stage_o <= par_i;
        else if (shift_i) stage_o <= shift_in(stage_o, din_i);
    end

    assert_load_follows_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> stage_o == $past(par_i));

    assert_shift_moves_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_i) |=> stage_o == {$past(stage_o[SECT_W-2:0]), $past(din_i)});

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_i) |=> $stable(stage_o));
endmodule

// File: rtl/piso_chain.sv
module piso_chain
    import piso_pkg::*;
#(
    parameter int N = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_n_i,
    input  logic            sclk_a_i,
    input  logic            sclk_b_i,
    input  logic            ser_i,
    input  logic [8*N-1:0]  par_i,
    output logic            ser_o,
    output logic            ser_n_o
);
    localparam int TOTAL = SECT_W * N;

    ctl_t   ctl_raw, ctl_s;
    logic   load, shift;
    stage_t stages [N];

    assign ctl_raw = '{load_n: load_n_i, clk_a: sclk_a_i, clk_b: sclk_b_i, ser: ser_i};

    piso_sync u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ctl_raw),
        .q_o (ctl_s)
    );

    piso_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl_s),
        .load_o  (load),
        .shift_o (shift)
    );

    for (genvar k = 0; k < N; k++) begin : g_sect
        logic din;
        if (k == 0) begin : g_head
            assign din = ctl_s.ser;
        end else begin : g_link
            assign din = stages[k-1][SECT_W-1];
        end

        piso_section u_sect (
            .clk     (clk),
            .rst     (rst),
            .load_i  (load),
            .shift_i (shift),
            .par_i   (par_i[k*SECT_W +: SECT_W]),
            .din_i   (din),
            .stage_o (stages[k])
        );
    end

    assign ser_o   = stages[N-1][SECT_W-1];
    assign ser_n_o = ~stages[N-1][SECT_W-1];

    // R9: after a load the serial output presents the top bit of the parallel word
    assert_top_bit_first_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> ser_o == $past(par_i[TOTAL-1]));
endmodule

// File: tb/piso_chain_test.sv
`timescale 1ns/1ps
module piso_chain_test;
    localparam int N = 2;
    localparam int W = 8 * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_n = 1'b1, ck_a = 1'b0, ck_b = 1'b0, ser_in = 1'b0;
    logic [W-1:0] par = '0;
    logic ser_o, ser_n_o;

    int checks = 0;
    int fails  = 0;
    logic q[$];

    localparam logic [W-1:0] WORDS [4] = '{16'hA5C3, 16'h0FF0, 16'h8001, 16'h7E5A};
    localparam logic [19:0]  DSPAT [4] = '{20'hF0F0F, 20'h12345, 20'hFFFFF, 20'h5A5A5};

    always #2.5 clk = ~clk;

    piso_chain #(.N(N)) uut (
        .clk(clk), .rst(rst), .load_n_i(load_n), .sclk_a_i(ck_a), .sclk_b_i(ck_b),
        .ser_i(ser_in), .par_i(par), .ser_o(ser_o), .ser_n_o(ser_n_o)
    );

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        check(tag, ser_o, q[0]);
        check({tag, " R8 inverted"}, ser_n_o, ~q[0]);
    endtask

    task automatic model_load(input logic [W-1:0] w);
        q.delete();
        for (int i = W - 1; i >= 0; i--) q.push_back(w[i]);
    endtask

    task automatic model_shift(input logic d);
        void'(q.pop_front());
        q.push_back(d);
    endtask

    task automatic pulse(input bit use_b, input logic d);
        ser_in = d;
        if (use_b) ck_b = 1'b1; else ck_a = 1'b1;
        settle();
        if (use_b) ck_b = 1'b0; else ck_a = 1'b0;
        settle();
        model_shift(d);
    endtask

    task automatic load_word(input logic [W-1:0] w);
        par = w;
        load_n = 1'b0;
        settle();
        model_load(w);
        load_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1 reset state
        check("R1 reset ser_o", ser_o, 1'b0);
        check("R1 reset ser_n_o", ser_n_o, 1'b1);

        // Table walk: load, release with clocks low, shift through with DS pattern
        for (int t = 0; t < 4; t++) begin
            par = WORDS[t];
            load_n = 1'b0;
            settle();
            model_load(WORDS[t]);
            check_out("R2 load");
            load_n = 1'b1;
            settle();
            check_out("R7 release clocks low");
            for (int j = 0; j < 20; j++) begin
                pulse(1'b0, DSPAT[t][j]);
                check_out("R3 R9 shift");
            end
        end

        // Load held while the clock toggles: register follows par
        load_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            par = 16'h1357 ^ (16'h8421 << i);
            ck_a = 1'b1;
            settle();
            check("R2 follow clk high", ser_o, par[W-1]);
            par = ~par;
            ck_a = 1'b0;
            settle();
            check("R2 follow clk low", ser_o, par[W-1]);
        end
        model_load(par);
        load_n = 1'b1;
        settle();
        for (int j = 0; j < W; j++) begin
            pulse(1'b0, 1'b0);
            check_out("R2 contents after toggled load");
        end

        // Enable-gated hold, release with enable high
        par = 16'hA5A5;
        load_n = 1'b0;
        settle();
        ck_b = 1'b1;
        settle();
        model_load(par);
        load_n = 1'b1;
        settle();
        check_out("R7 release enable high");
        for (int i = 0; i < 4; i++) begin
            ck_a = 1'b1;
            settle();
            check_out("R4 hold a high");
            ck_a = 1'b0;
            settle();
            check_out("R4 hold a low");
        end
        ck_b = 1'b0;
        settle();
        check_out("R4 enable fall no shift");
        // Hazard: enable rises while clock low
        ser_in = 1'b1;
        ck_b = 1'b1;
        settle();
        model_shift(1'b1);
        check_out("R6 enable rise shifts");
        ck_b = 1'b0;
        settle();
        check_out("R6 after enable fall");

        // Swapped inputs: shift with B only
        load_word(16'h3C96);
        check_out("R5 swapped load");
        for (int j = 0; j < W; j++) begin
            pulse(1'b1, j[0]);
            check_out("R5 swapped shift");
        end

        // Release with A high, then A falls
        par = 16'hC001;
        load_n = 1'b0;
        ck_a = 1'b1;
        settle();
        model_load(par);
        load_n = 1'b1;
        settle();
        check_out("R7 release a high");
        ck_a = 1'b0;
        settle();
        check_out("R7 a fall after release");

        // Held-high clock gives a single shift
        ser_in = 1'b0;
        ck_a = 1'b1;
        settle();
        model_shift(1'b0);
        check_out("R10 first edge");
        repeat (20) @(posedge clk);
        @(negedge clk);
        check_out("R10 held high");
        ck_a = 1'b0;
        settle();
        check_out("R10 after release");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule